// File: doc/BRIEF.md
# Single-bit test and modify unit

This execution unit handles the bit-manipulation instructions of a 32-bit CISC data path. The operand has already been read by the rest of the pipeline. The unit receives that operand, a bit number, a 2-bit operation kind, the 3-bit addressing-mode field of the target and a flag saying whether the bit number came from an immediate. It picks out the selected bit and reports its old value through the Z flag. For the three modifying kinds it also inverts, clears or sets that bit. One clock later it returns the value to write back, a write enable, the Z result and the number of cycles the instruction costs.

When the mode field is 000 the target is a data register, and the full 32-bit word is used. Mode 001 does not encode a bit instruction, and the unit reports it as illegal. Every other mode refers to a byte in memory: only the low byte of the operand takes part in the operation, and the rest of the returned word is zero. Address generation, bus traffic and flag bits other than Z are handled outside this unit.

Top module: `bittest_unit`

## Requirements
- R1: The operation kind `in_kind` selects what happens to the selected bit: 00 leaves the value unchanged (test only), 01 inverts the bit, 10 clears it to 0, and 11 sets it to 1. All other bits of the target keep their values.
- R2: `z_flag` is 1 exactly when the selected bit was 0 before any change, and `z_we` is 1 for every legal request.
- R3: If `in_mode` is 000, the target is the 32-bit operand. For any other legal mode the target is `in_operand[7:0]`, and `result[31:8]` is 0.
- R4: The bit number is taken modulo 32 for a register target and modulo 8 for a byte target. For example, 33 selects bit 1 of a register, and 9 selects bit 1 of a byte.
- R5: `wr_en` is 1 for kinds 01, 10 and 11. It is 0 for kind 00.
- R6: `cycles` is 4, plus 4 if the kind modifies the bit, plus 2 if the target is a register.
- R7: For a register target, the extra 2 cycles are not added when `in_imm` is 1 and the kind is 11 (set). With `in_imm` at 0, kind 11 on a register does pay the extra 2 cycles.
- R8: `in_mode` equal to 001 gives `illegal`=1, `wr_en`=0, `z_we`=0, `z_flag`=0, `cycles`=0 and `result` equal to `in_operand`.
- R9: All outputs are registered. `out_valid` follows `in_valid` one clock later. While reset is active, `out_valid`, `wr_en` and `z_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| in_operand | input | 32 | Target value that was already read |
| in_bitnum | input | 6 | Bit number, taken from a register or an immediate |
| in_kind | input | 2 | Operation kind: 00 test, 01 invert, 10 clear, 11 set |
| in_mode | input | 3 | Target addressing-mode field: 000 register, 001 illegal, others memory byte |
| in_imm | input | 1 | 1 when the bit number comes from an immediate |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Value to write back |
| wr_en | output | 1 | Write back `result` |
| z_flag | output | 1 | New Z flag value |
| z_we | output | 1 | Update Z from `z_flag` |
| illegal | output | 1 | Mode field does not encode a bit operation |
| cycles | output | 4 | Cycle cost of the instruction |

## Verification
The hardest case to reach is the reduced cost of R7. It only appears when three inputs line up at once: a register target, the immediate form and the set kind. It also has to be told apart from the same request without the immediate flag. The stimulus sends these neighbouring combinations back to back, so that a cost rule that is off by one condition produces a visible difference. Bit numbers above the width limit are also driven, for both target sizes, so that the modulo behaviour of R4 is checked. These cases are then mixed into a long random run that a reference model checks.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [1:0] {
      BK_TEST = 2'b00,
      BK_FLIP = 2'b01,
      BK_CLR  = 2'b10,
      BK_SET  = 2'b11
   } bit_kind_e;

   localparam logic [2:0] MODE_DREG = 3'b000;
   localparam logic [2:0] MODE_BAD  = 3'b001;
endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
   parameter int W     = 32,
   parameter int IDX_W = 5,
   parameter int STYLE = 0
) (
   input  logic [IDX_W-1:0] idx,
   output logic [W-1:0]     mask
);
   generate
      if (W != (1 << IDX_W)) begin : g_bad_w
         $error("bitop_mask: W must equal 2**IDX_W");
      end
      if (STYLE == 0) begin : g_shift
         // barrel-shift a single one into place
         assign mask = {{(W-1){1'b0}}, 1'b1} << idx;
      end else begin : g_decode
         // flat decoder: one comparator per bit
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign mask[i] = (idx == IDX_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] mask,
   input  bit_kind_e         kind,
   input  logic              to_reg,
   output logic [DATA_W-1:0] res,
   output logic              bit_zero
);
   logic [DATA_W-1:0] tgt;

   always_comb begin
      // a byte target only sees the low lane
      if (to_reg) tgt = opnd;
      else        tgt = {{(DATA_W-BYTE_W){1'b0}}, opnd[BYTE_W-1:0]};

      bit_zero = ((tgt & mask) == '0);

      unique case (kind)
         BK_FLIP: res = tgt ^ mask;
         BK_CLR:  res = tgt & ~mask;
         BK_SET:  res = tgt | mask;
         default: res = tgt;
      endcase
   end
endmodule

// File: rtl/bitop_cost.sv
module bitop_cost
   import bitop_pkg::*;
#(
   parameter int BASE_CYC = 4,
   parameter int REG_CYC  = 2,
   parameter int MOD_CYC  = 4,
   parameter int CYC_W    = 4
) (
   input  bit_kind_e         kind,
   input  logic              to_reg,
   input  logic              imm_form,
   input  logic              bad,
   output logic [CYC_W-1:0]  cyc
);
   logic modifies;
   logic reg_extra;

   always_comb begin
      modifies  = (kind != BK_TEST);
      // immediate-form set on a register skips the register surcharge
      reg_extra = to_reg && !(imm_form && kind == BK_SET);
      if (bad) begin
         cyc = '0;
      end else begin
         cyc = CYC_W'(BASE_CYC);
         if (modifies)  cyc = cyc + CYC_W'(MOD_CYC);
         if (reg_extra) cyc = cyc + CYC_W'(REG_CYC);
      end
   end
endmodule

// File: rtl/bittest_unit.sv
module bittest_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int BITNUM_W   = 6,
   parameter int MASK_STYLE = 0,
   parameter int BASE_CYC   = 4,
   parameter int REG_CYC    = 2,
   parameter int MOD_CYC    = 4,
   parameter int CYC_W      = $clog2(BASE_CYC + REG_CYC + MOD_CYC + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   in_operand,
   input  logic [BITNUM_W-1:0] in_bitnum,
   input  logic [1:0]          in_kind,
   input  logic [2:0]          in_mode,
   input  logic                in_imm,
   output logic                out_valid,
   output logic [DATA_W-1:0]   result,
   output logic                wr_en,
   output logic                z_flag,
   output logic                z_we,
   output logic                illegal,
   output logic [CYC_W-1:0]    cycles
);
   localparam int REG_IDX_W  = $clog2(DATA_W);
   localparam int BYTE_IDX_W = $clog2(BYTE_W);
   localparam int PAD_W      = REG_IDX_W - BYTE_IDX_W;

   generate
      if (DATA_W != (1 << REG_IDX_W)) begin : g_chk_dw
         $error("bittest_unit: DATA_W must be a power of two");
      end
      if (BYTE_W != (1 << BYTE_IDX_W) || BYTE_W >= DATA_W) begin : g_chk_bw
         $error("bittest_unit: BYTE_W must be a power of two below DATA_W");
      end
      if (BITNUM_W < REG_IDX_W) begin : g_chk_bn
         $error("bittest_unit: BITNUM_W too narrow");
      end
      if ((1 << CYC_W) <= BASE_CYC + REG_CYC + MOD_CYC) begin : g_chk_cy
         $error("bittest_unit: CYC_W too narrow for cost");
      end
   endgenerate

   bit_kind_e             kind;
   logic                  to_reg;
   logic                  bad;
   logic [REG_IDX_W-1:0]  idx;
   logic [DATA_W-1:0]     mask;
   logic [DATA_W-1:0]     alu_res;
   logic                  bit_zero;
   logic [CYC_W-1:0]      cyc_nx;

   always_comb begin
      kind   = bit_kind_e'(in_kind);
      bad    = (in_mode == MODE_BAD);
      to_reg = (in_mode == MODE_DREG);
      // modulo: register uses full index, byte keeps only its low bits
      if (to_reg) idx = in_bitnum[REG_IDX_W-1:0];
      else        idx = {{PAD_W{1'b0}}, in_bitnum[BYTE_IDX_W-1:0]};
   end

   bitop_mask #(
      .W     (DATA_W),
      .IDX_W (REG_IDX_W),
      .STYLE (MASK_STYLE)
   ) u_mask (
      .idx  (idx),
      .mask (mask)
   );

   bitop_alu #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_alu (
      .opnd     (in_operand),
      .mask     (mask),
      .kind     (kind),
      .to_reg   (to_reg),
      .res      (alu_res),
      .bit_zero (bit_zero)
   );

   bitop_cost #(
      .BASE_CYC (BASE_CYC),
      .REG_CYC  (REG_CYC),
      .MOD_CYC  (MOD_CYC),
      .CYC_W    (CYC_W)
   ) u_cost (
      .kind     (kind),
      .to_reg   (to_reg),
      .imm_form (in_imm),
      .bad      (bad),
      .cyc      (cyc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         z_flag    <= 1'b0;
         z_we      <= 1'b0;
         illegal   <= 1'b0;
         cycles    <= '0;
      end else begin
         out_valid <= in_valid;
         illegal   <= in_valid && bad;
         cycles    <= cyc_nx;
         if (bad) begin
            result <= in_operand;
            wr_en  <= 1'b0;
            z_flag <= 1'b0;
            z_we   <= 1'b0;
         end else begin
            result <= alu_res;
            wr_en  <= in_valid && (kind != BK_TEST);
            z_flag <= bit_zero;
            z_we   <= in_valid;
         end
      end
   end

   // R2: Z reflects the old register bit
   a_r2_z_old_bit: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_mode) == MODE_DREG
      |-> z_flag == ~$past(in_operand[in_bitnum[REG_IDX_W-1:0]]));

   // R3: byte targets return a zero upper part
   a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_mode) != MODE_DREG && !illegal
      |-> result[DATA_W-1:BYTE_W] == '0);

   // R5: test-only never writes
   a_r5_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_kind) == 2'b00 |-> !wr_en);

   // R6: legal costs never fall under the base
   a_r6_cost_floor: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !illegal |-> cycles >= CYC_W'(BASE_CYC));

   // R8: illegal mode suppresses every update
   a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_mode) == MODE_BAD |-> illegal && !wr_en && !z_we);

   // R9: no write or flag update without a valid result
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !wr_en && !z_we && !illegal);
endmodule

// File: tb/bittest_unit_test.sv
module bittest_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_operand = '0;
   logic [5:0]  in_bitnum = '0;
   logic [1:0]  in_kind = '0;
   logic [2:0]  in_mode = '0;
   logic        in_imm = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        wr_en;
   logic        z_flag;
   logic        z_we;
   logic        illegal;
   logic [3:0]  cycles;

   always #4 clk = ~clk;   // 125 MHz

   bittest_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
      .in_bitnum(in_bitnum), .in_kind(in_kind), .in_mode(in_mode), .in_imm(in_imm),
      .out_valid(out_valid), .result(result), .wr_en(wr_en), .z_flag(z_flag),
      .z_we(z_we), .illegal(illegal), .cycles(cycles)
   );

   typedef struct {
      logic [31:0] res;
      logic        we;
      logic        z;
      logic        zwe;
      logic        ill;
      logic [3:0]  cyc;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [31:0] op, input logic [5:0] bn,
                                  input logic [1:0] k, input logic [2:0] md,
                                  input logic im, input string tag);
      exp_t e;
      logic [31:0] v, m;
      int idx;
      bit isreg;
      e.tag = tag;
      if (md == 3'b001) begin
         e.res = op; e.we = 0; e.z = 0; e.zwe = 0; e.ill = 1; e.cyc = 0;
         return e;
      end
      isreg = (md == 3'b000);
      v   = isreg ? op : {24'h0, op[7:0]};
      idx = isreg ? (int'(bn) % 32) : (int'(bn) % 8);
      m   = 32'h1 << idx;
      e.z = (v[idx] == 1'b0);
      case (k)
         2'b01:   e.res = v ^ m;
         2'b10:   e.res = v & ~m;
         2'b11:   e.res = v | m;
         default: e.res = v;
      endcase
      e.we  = (k != 2'b00);
      e.zwe = 1;
      e.ill = 0;
      e.cyc = 4'd4 + ((k != 2'b00) ? 4'd4 : 4'd0)
              + ((isreg && !(im && k == 2'b11)) ? 4'd2 : 4'd0);
      return e;
   endfunction

   task automatic send(input logic [31:0] op, input logic [5:0] bn,
                       input logic [1:0] k, input logic [2:0] md,
                       input logic im, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_operand = op; in_bitnum = bn;
      in_kind = k; in_mode = md; in_imm = im;
      sb.push_back(model(op, bn, k, md, im, tag));
   endtask

   // monitor: compares each valid result against the queue front
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               check("R9", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, "result", result, e.res);
               check(e.tag, "wr_en R5", {31'd0, wr_en}, {31'd0, e.we});
               check(e.tag, "z_flag R2", {31'd0, z_flag}, {31'd0, e.z});
               check(e.tag, "z_we R2", {31'd0, z_we}, {31'd0, e.zwe});
               check(e.tag, "illegal R8", {31'd0, illegal}, {31'd0, e.ill});
               check(e.tag, "cycles R6", {28'd0, cycles}, {28'd0, e.cyc});
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
      check("R9", "reset wr_en", {31'd0, wr_en}, 32'd0);
      check("R9", "reset z_we", {31'd0, z_we}, 32'd0);
      rst_n = 1'b1;

      // R1: each kind on a register
      send(32'h0000_00F0, 6'd4,  2'b00, 3'b000, 1'b0, "R1_test");
      send(32'h0000_00F0, 6'd4,  2'b01, 3'b000, 1'b0, "R1_flip");
      send(32'h0000_00F0, 6'd4,  2'b10, 3'b000, 1'b0, "R1_clr");
      send(32'h0000_00F0, 6'd0,  2'b11, 3'b000, 1'b0, "R1_set");
      // R2: top bit, zero and one
      send(32'h8000_0000, 6'd31, 2'b00, 3'b000, 1'b0, "R2_top1");
      send(32'h7FFF_FFFF, 6'd31, 2'b00, 3'b000, 1'b0, "R2_top0");
      // R3: byte target ignores upper operand bits
      send(32'hFFFF_FF00, 6'd3,  2'b11, 3'b010, 1'b0, "R3_byte");
      send(32'hABCD_EF80, 6'd7,  2'b10, 3'b101, 1'b1, "R3_byte7");
      // R4: modulo bit numbers
      send(32'h0000_0002, 6'd33, 2'b00, 3'b000, 1'b0, "R4_reg33");
      send(32'h0000_0002, 6'd9,  2'b01, 3'b011, 1'b0, "R4_byte9");
      send(32'h0000_0200, 6'd9,  2'b00, 3'b011, 1'b0, "R4_byte9_hi");
      // R7: immediate set on register vs neighbours
      send(32'h0,         6'd5,  2'b11, 3'b000, 1'b1, "R7_imm_set");
      send(32'h0,         6'd5,  2'b11, 3'b000, 1'b0, "R7_dyn_set");
      send(32'h0,         6'd5,  2'b10, 3'b000, 1'b1, "R7_imm_clr");
      send(32'h0,         6'd5,  2'b11, 3'b111, 1'b1, "R7_imm_set_mem");
      // R8: illegal mode
      send(32'h1234_5678, 6'd3,  2'b11, 3'b001, 1'b0, "R8_illegal");
      // back-to-back random mix, all kinds, both widths
      for (int i = 0; i < 600; i++) begin
         logic [2:0] md;
         md = 3'($urandom_range(0, 7));
         send($urandom, 6'($urandom), 2'($urandom), md, 1'($urandom),
              (md == 3'b000) ? "R1_rand_reg" : "R3_rand_mem");
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      // R9: idle after traffic
      check("R9", "idle out_valid", {31'd0, out_valid}, 32'd0);
      check("R9", "queue drained", sb.size(), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule